// File: doc/BRIEF.md
# Redundant Reference Clock Switchover Controller

This block takes two reference clocks, input A and input B, and drives one of them onto a single output clock. A configuration bit decides which input is the primary source. The other input becomes the secondary source. A two-bit mode field selects manual or automatic switchover. In manual mode a select pin chooses primary or secondary. In automatic mode a loss-of-clock monitor moves the output to the secondary when the primary stops toggling, and moves it back once the primary has recovered.

Every change of source goes through a handshake with two enable flops per clock, both clocked on the falling edge. The clock being dropped is gated off on its own falling edge. The new clock is enabled on its falling edge only after the old enable has cleared. As a result the output never carries a pulse shorter than the shorter half period of the two inputs.

Automatic failover only works when input A is the primary. A crystal-mode setting pins the selection to input A. The block reports which source is active. It also keeps a sticky loss flag, which software clears with a write-one-to-clear strobe sampled by input B.

Top module: `refclk_switchover`

## Requirements
- R1: While `rst_n` is low, `clk_out` is held low and `los_sticky` reads 0.
- R2: `cfg_prim_b` = 0 makes input A the primary and B the secondary. `cfg_prim_b` = 1 makes B the primary and A the secondary. `active_sec` reads 0 while the primary drives `clk_out` and 1 while the secondary does.
- R3: With `cfg_mode[1]` = 0 (modes 00 and 01, manual) and `cfg_xtal` = 0, `sel_sec` = 0 routes the primary and `sel_sec` = 1 routes the secondary. `clk_out` then runs at the period of the chosen input.
- R4: While both inputs run, a change of source never puts a high or low phase on `clk_out` that is shorter than the shorter input half period.
- R5: In automatic mode with A primary and `cfg_xtal` = 0, two consecutive `clk_b` rising edges with no A edge seen cause a switch to B, and `active_sec` goes to 1. This holds even if `clk_a` stays stopped.
- R6: The automatic switch is revertive. After a loss, once at least 4 A rising edges are counted within an 8-cycle window of `clk_b`, the output returns to A.
- R7: In automatic mode with B primary, failover is suppressed. `clk_out` stays on B, `active_sec` stays 0 and no loss is flagged.
- R8: With `cfg_xtal` = 1 the selection stays on input A in every mode (`active_sec` equals `cfg_prim_b`), and no loss is flagged.
- R9: In automatic mode `sel_sec` has no effect on the selection.
- R10: `los_sticky` is set by a detected loss and stays set after the primary recovers. It is cleared by `los_clr` = 1 at a `clk_b` rising edge where no new loss is detected.
- R11: Mode values 10 and 11 both select automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Reference input A (crystal or reference pin) |
| clk_b | input | 1 | Reference input B; also clocks the loss monitor and the sticky flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prim_b | input | 1 | 0: A is primary, 1: B is primary |
| cfg_mode | input | 2 | Switchover mode; 0x manual, 1x automatic |
| cfg_xtal | input | 1 | Input A runs from a crystal; locks selection to A |
| sel_sec | input | 1 | Manual select: 0 primary, 1 secondary |
| los_clr | input | 1 | Write-one-to-clear for `los_sticky`, sampled on `clk_b` |
| clk_out | output | 1 | Selected reference clock |
| active_sec | output | 1 | 0 primary active, 1 secondary active |
| los_sticky | output | 1 | Sticky primary-loss flag |

## Verification
The inputs run at different periods: 7 ns for A and 5 ns for B. Measuring the period of `clk_out` therefore shows which clock is routed, independently of the `active_sec` indicator. Random configurations cover all combinations of primary bit, mode, crystal bit and select pin while both clocks run, and tell manual routing apart from the automatic, crystal-locked and suppressed cases. The narrowest `clk_out` phase over all those switches is checked to show the mux never produces runts. Directed runs then stop input A in three settings: A primary, B primary and crystal mode. They show a real failover in the first case only, then check reversion, the sticky flag, and that `sel_sec` has no effect while in automatic mode.

// File: rtl/refsw_pkg.sv
`timescale 1ns/1ps
package refsw_pkg;

   typedef enum logic [1:0] {
      SW_MANUAL_0 = 2'b00,
      SW_MANUAL_1 = 2'b01,
      SW_AUTO_0   = 2'b10,
      SW_AUTO_1   = 2'b11
   } sw_mode_e;

   // Upper mode bit alone decides automatic operation
   function automatic logic mode_is_auto(input logic [1:0] mode);
      return mode[1];
   endfunction

   typedef struct packed {
      logic use_b;      // route input B to the output
      logic mon_en;     // loss monitor armed
      logic active_sec; // secondary currently selected
   } route_t;

endpackage

// File: rtl/refsw_loss_mon.sv
`timescale 1ns/1ps
module refsw_loss_mon #(
   parameter int LOSS_CYC      = 2,
   parameter int RESTORE_EDGES = 4,
   parameter int RESTORE_WIN   = 8,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk_pri,
   input  logic clk_mon,
   input  logic rst_n,
   input  logic mon_en,
   output logic lost,
   output logic loss_evt
);
   localparam int QW = $clog2(LOSS_CYC + 1);
   localparam int WW = $clog2(RESTORE_WIN);
   localparam int EW = $clog2(RESTORE_WIN + 1);

   if (LOSS_CYC < 1) begin : g_bad_loss
      $error("refsw_loss_mon: LOSS_CYC must be at least 1");
   end
   if (RESTORE_WIN < 2) begin : g_bad_win
      $error("refsw_loss_mon: RESTORE_WIN must be at least 2");
   end
   if (RESTORE_EDGES < 1 || RESTORE_EDGES > RESTORE_WIN) begin : g_bad_edges
      $error("refsw_loss_mon: RESTORE_EDGES out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("refsw_loss_mon: SYNC_STAGES must be at least 2");
   end

   // Toggle flag in the monitored clock domain
   logic pri_tog;
   always_ff @(posedge clk_pri or negedge rst_n) begin
      if (!rst_n) pri_tog <= 1'b0;
      else        pri_tog <= ~pri_tog;
   end

   // Synchroniser plus one history stage for change detection
   logic [SYNC_STAGES:0] tog_sync;
   always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n) tog_sync <= '0;
      else        tog_sync <= {tog_sync[SYNC_STAGES-1:0], pri_tog};
   end

   logic edge_seen;
   assign edge_seen = tog_sync[SYNC_STAGES] ^ tog_sync[SYNC_STAGES-1];

   logic [QW-1:0] quiet_q;
   logic [WW-1:0] win_q;
   logic [EW-1:0] ecnt_q;
   logic [EW-1:0] ecnt_nxt;

   assign ecnt_nxt = ecnt_q + EW'(edge_seen);

   always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q  <= '0;
         win_q    <= '0;
         ecnt_q   <= '0;
         lost     <= 1'b0;
         loss_evt <= 1'b0;
      end else if (!mon_en) begin
         quiet_q  <= '0;
         win_q    <= '0;
         ecnt_q   <= '0;
         lost     <= 1'b0;
         loss_evt <= 1'b0;
      end else if (!lost) begin
         win_q  <= '0;
         ecnt_q <= '0;
         if (edge_seen) begin
            quiet_q  <= '0;
            loss_evt <= 1'b0;
         end else if (quiet_q == QW'(LOSS_CYC - 1)) begin
            quiet_q  <= '0;
            lost     <= 1'b1;
            loss_evt <= 1'b1;
         end else begin
            quiet_q  <= quiet_q + 1'b1;
            loss_evt <= 1'b0;
         end
      end else begin
         loss_evt <= 1'b0;
         quiet_q  <= '0;
         if (win_q == WW'(RESTORE_WIN - 1)) begin
            win_q  <= '0;
            ecnt_q <= '0;
            if (ecnt_nxt >= EW'(RESTORE_EDGES)) lost <= 1'b0;
         end else begin
            win_q  <= win_q + 1'b1;
            ecnt_q <= ecnt_nxt;
         end
      end
   end

endmodule

// File: rtl/refsw_route.sv
`timescale 1ns/1ps
module refsw_route
   import refsw_pkg::*;
(
   input  logic       clk_mon,
   input  logic       rst_n,
   input  logic       cfg_prim_b,
   input  logic [1:0] cfg_mode,
   input  logic       cfg_xtal,
   input  logic       sel_sec,
   input  logic       lost,
   input  logic       loss_evt,
   input  logic       los_clr,
   output route_t     route,
   output logic       los_sticky
);
   logic auto_m;
   assign auto_m = mode_is_auto(cfg_mode);

   always_comb begin
      route = '0;
      if (cfg_xtal) begin
         route.use_b = 1'b0;
      end else if (!auto_m) begin
         route.use_b = sel_sec ^ cfg_prim_b;
      end else if (cfg_prim_b) begin
         route.use_b = 1'b1;
      end else begin
         route.use_b  = lost;
         route.mon_en = 1'b1;
      end
      route.active_sec = route.use_b ^ cfg_prim_b;
   end

   always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n)        los_sticky <= 1'b0;
      else if (loss_evt) los_sticky <= 1'b1;
      else if (los_clr)  los_sticky <= 1'b0;
   end

endmodule

// File: rtl/refsw_gate_branch.sv
`timescale 1ns/1ps
module refsw_gate_branch #(
   parameter int EN_STAGES = 2
) (
   input  logic clk_src,
   input  logic rst_n,
   input  logic kill,
   input  logic req,
   input  logic other_on,
   output logic on
);
   if (EN_STAGES < 2) begin : g_bad_stages
      $error("refsw_gate_branch: EN_STAGES must be at least 2");
   end

   logic arst_n;
   assign arst_n = rst_n & ~kill;

   logic [EN_STAGES-1:0] en_q;
   always_ff @(negedge clk_src or negedge arst_n) begin
      if (!arst_n) en_q <= '0;
      else         en_q <= {en_q[EN_STAGES-2:0], req & ~other_on};
   end

   assign on = en_q[EN_STAGES-1];

endmodule

// File: rtl/refsw_clk_mux.sv
`timescale 1ns/1ps
module refsw_clk_mux #(
   parameter int EN_STAGES = 2
) (
   input  logic       clk_a,
   input  logic       clk_b,
   input  logic       rst_n,
   input  logic       kill_a,
   input  logic       use_b,
   output logic       clk_out,
   output logic [1:0] on_v
);
   localparam int NSRC = 2;

   logic [NSRC-1:0] clk_v;
   logic [NSRC-1:0] req_v;
   logic [NSRC-1:0] kill_v;

   assign clk_v  = {clk_b, clk_a};
   assign req_v  = {use_b, ~use_b};
   assign kill_v = {1'b0, kill_a};

   for (genvar g = 0; g < NSRC; g++) begin : g_branch
      refsw_gate_branch #(.EN_STAGES(EN_STAGES)) u_br (
         .clk_src  (clk_v[g]),
         .rst_n    (rst_n),
         .kill     (kill_v[g]),
         .req      (req_v[g]),
         .other_on (on_v[NSRC-1-g]),
         .on       (on_v[g])
      );
   end

   assign clk_out = |(clk_v & on_v);

endmodule

// File: rtl/refclk_switchover.sv
`timescale 1ns/1ps
module refclk_switchover
   import refsw_pkg::*;
#(
   parameter int LOSS_CYC      = 2,
   parameter int RESTORE_EDGES = 4,
   parameter int RESTORE_WIN   = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int EN_STAGES     = 2
) (
   input  logic       clk_a,
   input  logic       clk_b,
   input  logic       rst_n,
   input  logic       cfg_prim_b,
   input  logic [1:0] cfg_mode,
   input  logic       cfg_xtal,
   input  logic       sel_sec,
   input  logic       los_clr,
   output logic       clk_out,
   output logic       active_sec,
   output logic       los_sticky
);
   route_t     route;
   logic       mon_lost;
   logic       mon_evt;
   logic [1:0] mux_on;

   refsw_loss_mon #(
      .LOSS_CYC      (LOSS_CYC),
      .RESTORE_EDGES (RESTORE_EDGES),
      .RESTORE_WIN   (RESTORE_WIN),
      .SYNC_STAGES   (SYNC_STAGES)
   ) u_mon (
      .clk_pri  (clk_a),
      .clk_mon  (clk_b),
      .rst_n    (rst_n),
      .mon_en   (route.mon_en),
      .lost     (mon_lost),
      .loss_evt (mon_evt)
   );

   refsw_route u_route (
      .clk_mon    (clk_b),
      .rst_n      (rst_n),
      .cfg_prim_b (cfg_prim_b),
      .cfg_mode   (cfg_mode),
      .cfg_xtal   (cfg_xtal),
      .sel_sec    (sel_sec),
      .lost       (mon_lost),
      .loss_evt   (mon_evt),
      .los_clr    (los_clr),
      .route      (route),
      .los_sticky (los_sticky)
   );

   // A stopped primary cannot gate itself off; the loss flag clears its enable
   refsw_clk_mux #(.EN_STAGES(EN_STAGES)) u_mux (
      .clk_a   (clk_a),
      .clk_b   (clk_b),
      .rst_n   (rst_n),
      .kill_a  (mon_lost),
      .use_b   (route.use_b),
      .clk_out (clk_out),
      .on_v    (mux_on)
   );

   assign active_sec = route.active_sec;

endmodule

// File: rtl/refclk_switchover_chk.sv
`timescale 1ns/1ps
module refclk_switchover_chk (
   input logic       clk_b,
   input logic       rst_n,
   input logic       cfg_prim_b,
   input logic [1:0] cfg_mode,
   input logic       cfg_xtal,
   input logic       sel_sec,
   input logic       los_clr,
   input logic       active_sec,
   input logic       los_sticky,
   input logic       lost,
   input logic       loss_evt,
   input logic [1:0] on_v
);
   // R3
   manual_follow_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      (!cfg_mode[1] && !cfg_xtal) |-> (active_sec == sel_sec));

   // R4
   one_enable_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      $onehot0(on_v));

   // R5
   auto_fail_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      (cfg_mode[1] && !cfg_prim_b && !cfg_xtal) |-> (active_sec == lost));

   // R7
   prim_b_hold_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      (cfg_mode[1] && cfg_prim_b && !cfg_xtal) |-> (!active_sec && !lost));

   // R8
   xtal_lock_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      cfg_xtal |-> (active_sec == cfg_prim_b && !lost));

   // R10
   sticky_set_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      loss_evt |=> los_sticky);

   // R10
   sticky_clr_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      (los_clr && !loss_evt) |=> !los_sticky);

endmodule

bind refclk_switchover refclk_switchover_chk u_chk (
   .clk_b      (clk_b),
   .rst_n      (rst_n),
   .cfg_prim_b (cfg_prim_b),
   .cfg_mode   (cfg_mode),
   .cfg_xtal   (cfg_xtal),
   .sel_sec    (sel_sec),
   .los_clr    (los_clr),
   .active_sec (active_sec),
   .los_sticky (los_sticky),
   .lost       (mon_lost),
   .loss_evt   (mon_evt),
   .on_v       (mux_on)
);

// File: tb/tb_refclk_switchover.sv
`timescale 1ns/1ps
module tb_refclk_switchover;

   logic       clk_a = 1'b0;
   logic       clk_b = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_prim_b = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic       cfg_xtal = 1'b0;
   logic       sel_sec = 1'b0;
   logic       los_clr = 1'b0;
   logic       clk_out;
   logic       active_sec;
   logic       los_sticky;

   logic run_a = 1'b1;
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;

   // 200 MHz on input B, 7 ns on input A (stoppable, parks low)
   always #2.5 clk_b = ~clk_b;
   always #3.5 clk_a = run_a ? ~clk_a : 1'b0;

   refclk_switchover dut (
      .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
      .cfg_prim_b(cfg_prim_b), .cfg_mode(cfg_mode), .cfg_xtal(cfg_xtal),
      .sel_sec(sel_sec), .los_clr(los_clr),
      .clk_out(clk_out), .active_sec(active_sec), .los_sticky(los_sticky)
   );

   // Narrowest output phase while monitoring is on
   bit      gmon = 1'b0;
   realtime last_t = 0.0;
   realtime min_w = 1000.0;
   always @(clk_out) begin
      if (gmon && last_t > 0.0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
      last_t = $realtime;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wait_b(input int n);
      repeat (n) @(negedge clk_b);
   endtask

   task automatic period_ps(output int p);
      realtime t0;
      @(posedge clk_out);
      t0 = $realtime;
      @(posedge clk_out);
      p = int'(($realtime - t0) * 1000.0);
   endtask

   // Expected routing from the requirements: returns 1 when B drives the output
   function automatic bit exp_use_b(bit prim_b, bit [1:0] mode, bit xtal, bit sel, bit lost);
      if (xtal)          return 1'b0;
      if (!mode[1])      return sel ^ prim_b;
      if (prim_b)        return 1'b1;
      return lost;
   endfunction

   function automatic int exp_period(bit use_b);
      return use_b ? 5000 : 7000;
   endfunction

   initial begin : watchdog
      #500000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin : stim
      int p;
      bit ub;
      int unsigned seed;
      seed = $urandom(32'd24680);

      // R1 reset state
      #12;
      check("R1 clk_out low in reset", int'(clk_out), 0);
      check("R1 los_sticky clear in reset", int'(los_sticky), 0);
      @(negedge clk_b);
      rst_n = 1'b1;
      wait_b(10);
      gmon = 1'b1;

      // R2/R3 manual, A primary
      period_ps(p);
      check("R3 manual primary A period", p, 7000);
      check("R2 active_sec primary", int'(active_sec), 0);
      @(negedge clk_b); sel_sec = 1'b1; wait_b(20);
      period_ps(p);
      check("R3 manual secondary B period", p, 5000);
      check("R2 active_sec secondary", int'(active_sec), 1);

      // R2/R3 manual, B primary
      @(negedge clk_b); cfg_prim_b = 1'b1; sel_sec = 1'b0; wait_b(20);
      period_ps(p);
      check("R2 B primary period", p, 5000);
      check("R2 B primary active_sec", int'(active_sec), 0);
      @(negedge clk_b); sel_sec = 1'b1; wait_b(20);
      period_ps(p);
      check("R3 B primary, secondary A period", p, 7000);
      check("R3 B primary, secondary active_sec", int'(active_sec), 1);

      // Random configurations, both clocks running (R3 R7 R8 R9 R11)
      for (int i = 0; i < 16; i++) begin
         @(negedge clk_b);
         cfg_prim_b = 1'($urandom());
         cfg_mode   = 2'($urandom());
         cfg_xtal   = (($urandom() % 4) == 0);
         sel_sec    = 1'($urandom());
         ub = exp_use_b(cfg_prim_b, cfg_mode, cfg_xtal, sel_sec, 1'b0);
         wait_b(24);
         check("R3/R8/R9/R11 random active_sec", int'(active_sec), int'(ub ^ cfg_prim_b));
         period_ps(p);
         check("R3/R8/R9/R11 random period", p, exp_period(ub));
      end

      // R4 narrowest phase across all switches so far
      gmon = 1'b0;
      check("R4 min phase >= 2500 ps", (int'(min_w * 1000.0) >= 2499) ? 1 : 0, 1);

      // R9 select ignored in auto mode with a healthy primary
      @(negedge clk_b);
      cfg_prim_b = 1'b0; cfg_mode = 2'b10; cfg_xtal = 1'b0; sel_sec = 1'b1;
      wait_b(24);
      check("R9 sel_sec ignored, active_sec", int'(active_sec), 0);
      period_ps(p);
      check("R9 sel_sec ignored, period A", p, 7000);
      check("R10 no loss yet", int'(los_sticky), 0);

      // R5/R11 primary A stops, mode 11
      @(negedge clk_b); cfg_mode = 2'b11; sel_sec = 1'b0;
      wait_b(4);
      run_a = 1'b0;
      wait_b(20);
      check("R5 failover active_sec", int'(active_sec), 1);
      check("R10 sticky set on loss", int'(los_sticky), 1);
      period_ps(p);
      check("R5 failover period B", p, 5000);
      @(negedge clk_b); sel_sec = 1'b1; wait_b(8);
      check("R9 sel_sec ignored while lost", int'(active_sec), 1);
      @(negedge clk_b); sel_sec = 1'b0;

      // R6 primary returns
      run_a = 1'b1;
      wait_b(40);
      check("R6 revert active_sec", int'(active_sec), 0);
      period_ps(p);
      check("R6 revert period A", p, 7000);
      check("R10 sticky kept after revert", int'(los_sticky), 1);
      @(negedge clk_b); los_clr = 1'b1;
      @(negedge clk_b); los_clr = 1'b0;
      wait_b(1);
      check("R10 sticky cleared", int'(los_sticky), 0);

      // R7 B primary in auto: no failover logic, stays on B
      @(negedge clk_b); cfg_prim_b = 1'b1; cfg_mode = 2'b10; sel_sec = 1'b1;
      wait_b(20);
      run_a = 1'b0;
      wait_b(30);
      check("R7 B primary auto active_sec", int'(active_sec), 0);
      check("R7 B primary auto no loss flag", int'(los_sticky), 0);
      period_ps(p);
      check("R7 B primary auto period", p, 5000);
      run_a = 1'b1;

      // R8 crystal mode pins A, even when A stops in auto mode
      @(negedge clk_b); cfg_prim_b = 1'b0; cfg_mode = 2'b10; cfg_xtal = 1'b1; sel_sec = 1'b0;
      wait_b(30);
      run_a = 1'b0;
      wait_b(30);
      check("R8 xtal holds A active_sec", int'(active_sec), 0);
      check("R8 xtal no loss flag", int'(los_sticky), 0);
      run_a = 1'b1;
      wait_b(20);
      period_ps(p);
      check("R8 xtal period A", p, 7000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule